// File: doc/BRIEF.md
# DMA Channel Register Interface

This block is the software-facing register file of a four-channel DMA engine. A 16-bit bus slave decodes a channel number and a word index from each address. It then reads or writes that channel's control, status, counter, address, vector and function-code registers. Every access can be narrowed to either byte lane. Status bits are cleared by writing ones to them. A write to a channel's control byte is turned into one-cycle command pulses (start, abort, halt, continue) for the transfer engine.

The transfer engine lives outside this block. It reports progress through a small set port, which ORs bits into a channel's status byte and can load that channel's error code. It reads the channel setup through flat export buses. Register contents otherwise change only through the bus.

Top module: `dma_chan_regs`

## Requirements
- R1: After a synchronous reset, both interrupt vectors of every channel read 0x000F. Every other mapped register, including the status/error word, reads 0x0000. `bus_rdata` is 0 and no command pulse is active.
- R2: For a bus access, the channel is `bus_addr[7:6]` and the word index is `bus_addr[5:1]`. A write changes only the addressed register of the addressed channel.
- R3: A read of an unmapped word index returns 0x00FF. A write to an unmapped index changes nothing. The mapped indices are 0x00, 0x02, 0x03, 0x05, 0x06, 0x07, 0x0A, 0x0B, 0x0D, 0x0E, 0x0F, 0x12, 0x13, 0x14, 0x16, 0x18, 0x1C and 0x1F.
- R4: Read data appears on `bus_rdata` one clock after the edge that samples the read, and holds in every cycle without a read. A read has no side effect.
- R5: `bus_be[1]` enables bits 15:8 and `bus_be[0]` enables bits 7:0. A disabled lane leaves its byte unchanged. The byte-wide registers (indices 0x12 to 0x1F) sit in the low lane and read with a zero high byte.
- R6: The 32-bit memory, device and base addresses are split across two indices each: high half at 0x06, 0x0A and 0x0E, low half at 0x07, 0x0B and 0x0F. Writing one half leaves the other half unchanged. Index 0x05 is the transfer count and 0x0D is the base count. Index 0x02 holds device control (high byte) and operation control (low byte).
- R7: Index 0x00 reads as status in the high byte and error code in the low byte. A high-lane write clears exactly the status bits that are 1 in both the written byte and 0xF6, so bits 0 and 3 cannot be cleared from the bus.
- R8: A high-lane write to index 0x00 with bit 12 set resets the error code to 0. No other bus write changes the error code.
- R9: When `eng_vld` is high, `eng_set` is ORed into the status of channel `eng_ch`. If `eng_set` bit 4 is set, `eng_code` is loaded into that channel's error code. An engine set wins over a bus clear in the same cycle.
- R10: Index 0x03 holds sequence control (high byte) and channel control (low byte). A low-lane write there stores the byte. In the next cycle only, it drives `cmd_start`, `cmd_abort`, `cmd_halt` and `cmd_cont` from written bits 7, 4, 5 and 6, with `cmd_ch` set to the written channel.
- R11: No command pulse follows a cycle without a low-lane write to index 0x03. This covers reads, other indices and high-lane-only writes.
- R12: The export buses carry each channel's stored device, operation and sequence control bytes, counts and addresses. Channel n occupies slice n of each bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Address bits 7:1 (channel in 7:6, word index in 5:1) |
| bus_be | input | 2 | Byte-lane enables, bit 1 = high byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| eng_vld | input | 1 | Engine status report valid |
| eng_ch | input | 2 | Channel of the report |
| eng_set | input | 8 | Status bits to set |
| eng_code | input | 8 | Error code, loaded when eng_set bit 4 is 1 |
| cmd_start | output | 1 | Start pulse |
| cmd_abort | output | 1 | Abort pulse |
| cmd_halt | output | 1 | Halt pulse |
| cmd_cont | output | 1 | Continue pulse |
| cmd_ch | output | 2 | Channel of the command pulses |
| dev_ctl_o | output | 32 | Device control byte per channel |
| op_ctl_o | output | 32 | Operation control byte per channel |
| seq_ctl_o | output | 32 | Sequence control byte per channel |
| xcnt_o | output | 64 | Transfer count per channel |
| madr_o | output | 128 | Memory address per channel |
| dadr_o | output | 128 | Device address per channel |
| bcnt_o | output | 64 | Base count per channel |
| badr_o | output | 128 | Base address per channel |

## Verification
A write or an engine report takes effect at the clock edge that samples it, so the export buses and any later read reflect it right after that edge. Read data and command pulses pass through one register each. Both are due one clock after the sampling edge, and a pulse lasts exactly that one cycle. The bench drives every access on a falling edge and samples at the next falling edge, which falls in the cycle where read data and pulses are valid. Rdata-hold checks are made after idle cycles and after writes, where no new read data may appear.

// File: rtl/dma_regs_pkg.sv
// Package: shared constants and types for the DMA channel register file.
// Assumes a 16-bit data bus and a 5-bit word index inside each channel window.
package dma_regs_pkg;

    localparam int DW    = 16;
    localparam int IDX_W = 5;

    // Word indices inside a channel window (software decodes these)
    localparam logic [IDX_W-1:0] IX_STAT   = 5'h00;
    localparam logic [IDX_W-1:0] IX_DOCTL  = 5'h02;
    localparam logic [IDX_W-1:0] IX_SCCTL  = 5'h03;
    localparam logic [IDX_W-1:0] IX_XCNT   = 5'h05;
    localparam logic [IDX_W-1:0] IX_MADR_H = 5'h06;
    localparam logic [IDX_W-1:0] IX_MADR_L = 5'h07;
    localparam logic [IDX_W-1:0] IX_DADR_H = 5'h0a;
    localparam logic [IDX_W-1:0] IX_DADR_L = 5'h0b;
    localparam logic [IDX_W-1:0] IX_BCNT   = 5'h0d;
    localparam logic [IDX_W-1:0] IX_BADR_H = 5'h0e;
    localparam logic [IDX_W-1:0] IX_BADR_L = 5'h0f;
    localparam logic [IDX_W-1:0] IX_NVEC   = 5'h12;
    localparam logic [IDX_W-1:0] IX_EVEC   = 5'h13;
    localparam logic [IDX_W-1:0] IX_MFC    = 5'h14;
    localparam logic [IDX_W-1:0] IX_PRIO   = 5'h16;
    localparam logic [IDX_W-1:0] IX_DFC    = 5'h18;
    localparam logic [IDX_W-1:0] IX_BFC    = 5'h1c;
    localparam logic [IDX_W-1:0] IX_GEN    = 5'h1f;

    localparam logic [7:0]    STAT_CLR_MASK = 8'hF6;
    localparam int            STAT_ERR_BIT  = 4;
    localparam logic [7:0]    VEC_RST       = 8'h0F;
    localparam logic [DW-1:0] UNMAPPED_WORD = 16'h00FF;

    // One channel's architectural state
    typedef struct packed {
        logic [7:0]  stat;
        logic [7:0]  err;
        logic [7:0]  dev_ctl;
        logic [7:0]  op_ctl;
        logic [7:0]  seq_ctl;
        logic [7:0]  ch_ctl;
        logic [15:0] xcnt;
        logic [31:0] madr;
        logic [31:0] dadr;
        logic [15:0] bcnt;
        logic [31:0] badr;
        logic [7:0]  nvec;
        logic [7:0]  evec;
        logic [7:0]  mfc;
        logic [7:0]  prio;
        logic [7:0]  dfc;
        logic [7:0]  bfc;
        logic [7:0]  gen;
    } chan_regs_t;

    // Reset image of a channel: vectors at their default, all else zero
    function automatic chan_regs_t chan_reset();
        chan_regs_t r;
        r      = '0;
        r.nvec = VEC_RST;
        r.evec = VEC_RST;
        return r;
    endfunction

    // Merge a 16-bit write into an old value under two byte enables
    function automatic logic [15:0] put16(input logic [15:0] old,
                                          input logic [15:0] nw,
                                          input logic [1:0]  be);
        return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
    endfunction

endpackage

// File: rtl/dma_regs_decode.sv
// Module: splits a bus access into channel and word index and qualifies it.
// Assumes bus_addr carries byte-address bits down to 1 (bit 0 not present).
module dma_regs_decode
    import dma_regs_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [IDX_W+CH_W:1]   bus_addr,
    input  logic                  be_lo,
    output logic [CH_W-1:0]       acc_ch,
    output logic [IDX_W-1:0]      acc_idx,
    output logic                  wr_hit,
    output logic                  rd_hit,
    output logic                  cmd_hit
);

    // Field extraction and access qualification
    always_comb begin
        acc_ch  = bus_addr[IDX_W+CH_W:IDX_W+1];
        acc_idx = bus_addr[IDX_W:1];
        wr_hit  = bus_sel && bus_wr;
        rd_hit  = bus_sel && !bus_wr;
        cmd_hit = wr_hit && be_lo && (acc_idx == IX_SCCTL);
    end

endmodule

// File: rtl/dma_regs_chan.sv
// Module: state of one DMA channel: bus writes with byte lanes, masked
// write-1-to-clear status and engine status reports.
// Assumes wr_en is already qualified with this channel's number.
module dma_regs_chan
    import dma_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        be,
    input  logic [DW-1:0]     wdata,
    input  logic              eng_en,
    input  logic [7:0]        eng_set,
    input  logic [7:0]        eng_code,
    output chan_regs_t        regs_o
);

    chan_regs_t r;
    logic [7:0] clr_bits;
    logic [7:0] set_bits;
    logic [7:0] stat_nx;
    logic [7:0] err_nx;

    // Status next-state: bus clears first, engine sets override
    always_comb begin
        clr_bits = (wr_en && idx == IX_STAT && be[1]) ? (wdata[15:8] & STAT_CLR_MASK) : 8'h00;
        set_bits = eng_en ? eng_set : 8'h00;
        stat_nx  = (r.stat & ~clr_bits) | set_bits;
        if (set_bits[STAT_ERR_BIT])
            err_nx = eng_code;
        else if (clr_bits[STAT_ERR_BIT])
            err_nx = 8'h00;
        else
            err_nx = r.err;
    end

    // Register update: reset image, status path, then addressed bus write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r <= chan_reset();
        end else begin
            r.stat <= stat_nx;
            r.err  <= err_nx;
            if (wr_en) begin
                case (idx)
                    IX_DOCTL:  {r.dev_ctl, r.op_ctl} <= put16({r.dev_ctl, r.op_ctl}, wdata, be);
                    IX_SCCTL:  {r.seq_ctl, r.ch_ctl} <= put16({r.seq_ctl, r.ch_ctl}, wdata, be);
                    IX_XCNT:   r.xcnt         <= put16(r.xcnt, wdata, be);
                    IX_MADR_H: r.madr[31:16]  <= put16(r.madr[31:16], wdata, be);
                    IX_MADR_L: r.madr[15:0]   <= put16(r.madr[15:0], wdata, be);
                    IX_DADR_H: r.dadr[31:16]  <= put16(r.dadr[31:16], wdata, be);
                    IX_DADR_L: r.dadr[15:0]   <= put16(r.dadr[15:0], wdata, be);
                    IX_BCNT:   r.bcnt         <= put16(r.bcnt, wdata, be);
                    IX_BADR_H: r.badr[31:16]  <= put16(r.badr[31:16], wdata, be);
                    IX_BADR_L: r.badr[15:0]   <= put16(r.badr[15:0], wdata, be);
                    IX_NVEC:   if (be[0]) r.nvec <= wdata[7:0];
                    IX_EVEC:   if (be[0]) r.evec <= wdata[7:0];
                    IX_MFC:    if (be[0]) r.mfc  <= wdata[7:0];
                    IX_PRIO:   if (be[0]) r.prio <= wdata[7:0];
                    IX_DFC:    if (be[0]) r.dfc  <= wdata[7:0];
                    IX_BFC:    if (be[0]) r.bfc  <= wdata[7:0];
                    IX_GEN:    if (be[0]) r.gen  <= wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    assign regs_o = r;

endmodule

// File: rtl/dma_regs_rdmux.sv
// Module: maps one channel's state and a word index to the 16-bit read word.
// Purely combinational; unmapped indices yield the fixed filler word.
module dma_regs_rdmux
    import dma_regs_pkg::*;
(
    input  chan_regs_t        regs,
    input  logic [IDX_W-1:0]  idx,
    output logic [DW-1:0]     rword
);

    // Read word selection by index
    always_comb begin
        case (idx)
            IX_STAT:   rword = {regs.stat, regs.err};
            IX_DOCTL:  rword = {regs.dev_ctl, regs.op_ctl};
            IX_SCCTL:  rword = {regs.seq_ctl, regs.ch_ctl};
            IX_XCNT:   rword = regs.xcnt;
            IX_MADR_H: rword = regs.madr[31:16];
            IX_MADR_L: rword = regs.madr[15:0];
            IX_DADR_H: rword = regs.dadr[31:16];
            IX_DADR_L: rword = regs.dadr[15:0];
            IX_BCNT:   rword = regs.bcnt;
            IX_BADR_H: rword = regs.badr[31:16];
            IX_BADR_L: rword = regs.badr[15:0];
            IX_NVEC:   rword = {8'h00, regs.nvec};
            IX_EVEC:   rword = {8'h00, regs.evec};
            IX_MFC:    rword = {8'h00, regs.mfc};
            IX_PRIO:   rword = {8'h00, regs.prio};
            IX_DFC:    rword = {8'h00, regs.dfc};
            IX_BFC:    rword = {8'h00, regs.bfc};
            IX_GEN:    rword = {8'h00, regs.gen};
            default:   rword = UNMAPPED_WORD;
        endcase
    end

endmodule

// File: rtl/dma_chan_regs.sv
// Module: top of the DMA channel register file. Decodes bus accesses,
// holds NUM_CH channel states, registers read data and command pulses,
// and exports each channel's setup to the transfer engine.
// Assumes NUM_CH is a power of two so every channel code is populated.
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter  int NUM_CH = 4,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = IDX_W + 1 + CH_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:1]       bus_addr,
    input  logic [1:0]              bus_be,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    input  logic                    eng_vld,
    input  logic [CH_W-1:0]         eng_ch,
    input  logic [7:0]              eng_set,
    input  logic [7:0]              eng_code,
    output logic                    cmd_start,
    output logic                    cmd_abort,
    output logic                    cmd_halt,
    output logic                    cmd_cont,
    output logic [CH_W-1:0]         cmd_ch,
    output logic [NUM_CH*8-1:0]     dev_ctl_o,
    output logic [NUM_CH*8-1:0]     op_ctl_o,
    output logic [NUM_CH*8-1:0]     seq_ctl_o,
    output logic [NUM_CH*16-1:0]    xcnt_o,
    output logic [NUM_CH*32-1:0]    madr_o,
    output logic [NUM_CH*32-1:0]    dadr_o,
    output logic [NUM_CH*16-1:0]    bcnt_o,
    output logic [NUM_CH*32-1:0]    badr_o
);

    logic [CH_W-1:0]  acc_ch;
    logic [IDX_W-1:0] acc_idx;
    logic             wr_hit;
    logic             rd_hit;
    logic             cmd_hit;
    chan_regs_t       regs [NUM_CH];
    chan_regs_t       sel_regs;
    logic [DW-1:0]    rd_word;
    logic [DW-1:0]    rdata_q;
    logic [3:0]       cmd_q;
    logic [CH_W-1:0]  cmd_ch_q;

    dma_regs_decode #(.CH_W(CH_W)) u_decode (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .be_lo    (bus_be[0]),
        .acc_ch   (acc_ch),
        .acc_idx  (acc_idx),
        .wr_hit   (wr_hit),
        .rd_hit   (rd_hit),
        .cmd_hit  (cmd_hit)
    );

    // One state block per channel plus its slice of every export bus
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dma_regs_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_hit && acc_ch == CH_W'(g)),
            .idx      (acc_idx),
            .be       (bus_be),
            .wdata    (bus_wdata),
            .eng_en   (eng_vld && eng_ch == CH_W'(g)),
            .eng_set  (eng_set),
            .eng_code (eng_code),
            .regs_o   (regs[g])
        );
        assign dev_ctl_o[g*8  +: 8]  = regs[g].dev_ctl;
        assign op_ctl_o [g*8  +: 8]  = regs[g].op_ctl;
        assign seq_ctl_o[g*8  +: 8]  = regs[g].seq_ctl;
        assign xcnt_o   [g*16 +: 16] = regs[g].xcnt;
        assign madr_o   [g*32 +: 32] = regs[g].madr;
        assign dadr_o   [g*32 +: 32] = regs[g].dadr;
        assign bcnt_o   [g*16 +: 16] = regs[g].bcnt;
        assign badr_o   [g*32 +: 32] = regs[g].badr;
    end

    // Channel select for the read path
    assign sel_regs = regs[acc_ch];

    dma_regs_rdmux u_rdmux (
        .regs  (sel_regs),
        .idx   (acc_idx),
        .rword (rd_word)
    );

    // Read data register: loads on a read, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_hit)
            rdata_q <= rd_word;
    end

    // Command pulse register: one cycle after a control-byte write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            cmd_ch_q <= '0;
        end else begin
            cmd_q <= cmd_hit ? {bus_wdata[7], bus_wdata[4], bus_wdata[5], bus_wdata[6]} : 4'b0000;
            if (cmd_hit)
                cmd_ch_q <= acc_ch;
        end
    end

    assign bus_rdata = rdata_q;
    assign cmd_start = cmd_q[3];
    assign cmd_abort = cmd_q[2];
    assign cmd_halt  = cmd_q[1];
    assign cmd_cont  = cmd_q[0];
    assign cmd_ch    = cmd_ch_q;

endmodule

// File: rtl/dma_chan_regs_chk.sv
// Module: assertion checker bound to dma_chan_regs; observes ports only.
module dma_chan_regs_chk #(
    parameter  int NUM_CH = 4,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [CH_W+5:1]   bus_addr,
    input logic              be_lo,
    input logic [3:0]        ctl_bits,
    input logic [15:0]       bus_rdata,
    input logic              cmd_start,
    input logic              cmd_abort,
    input logic              cmd_halt,
    input logic              cmd_cont,
    input logic [CH_W-1:0]   cmd_ch
);

    logic [4:0] widx;
    logic       ctl_w;
    logic       rd_w;
    logic       any_cmd;
    logic       unmapped;

    // Observed access classification
    always_comb begin
        widx     = bus_addr[5:1];
        ctl_w    = bus_sel && bus_wr && be_lo && widx == 5'd3;
        rd_w     = bus_sel && !bus_wr;
        any_cmd  = cmd_start || cmd_abort || cmd_halt || cmd_cont;
        unmapped = !(widx inside {5'd0, 5'd2, 5'd3, 5'd5, 5'd6, 5'd7, 5'd10, 5'd11,
                                  5'd13, 5'd14, 5'd15, 5'd18, 5'd19, 5'd20, 5'd22,
                                  5'd24, 5'd28, 5'd31});
    end

    p_start_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && ctl_bits[3]) |=> cmd_start);

    p_abort_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && ctl_bits[0]) |=> cmd_abort);

    p_pulse_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        any_cmd |-> $past(ctl_w));

    p_cmd_chan_r10: assert property (@(posedge clk) disable iff (!rst_n)
        any_cmd |-> cmd_ch == $past(bus_addr[CH_W+5:6]));

    p_no_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_w |=> !any_cmd);

    p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_w |=> $stable(bus_rdata));

    p_unmapped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_w && unmapped) |=> bus_rdata == 16'h00FF);

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .be_lo     (bus_be[0]),
    .ctl_bits  (bus_wdata[7:4]),
    .bus_rdata (bus_rdata),
    .cmd_start (cmd_start),
    .cmd_abort (cmd_abort),
    .cmd_halt  (cmd_halt),
    .cmd_cont  (cmd_cont),
    .cmd_ch    (cmd_ch)
);

// File: tb/dma_chan_regs_bench.sv
// Bench: sweeps all channels and indices against an arithmetic model.
module dma_chan_regs_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:1]   bus_addr = '0;
    logic [1:0]   bus_be = '0;
    logic [15:0]  bus_wdata = '0;
    logic [15:0]  bus_rdata;
    logic         eng_vld = 1'b0;
    logic [1:0]   eng_ch = '0;
    logic [7:0]   eng_set = '0;
    logic [7:0]   eng_code = '0;
    logic         cmd_start, cmd_abort, cmd_halt, cmd_cont;
    logic [1:0]   cmd_ch;
    logic [31:0]  dev_ctl_o, op_ctl_o, seq_ctl_o;
    logic [63:0]  xcnt_o, bcnt_o;
    logic [127:0] madr_o, dadr_o, badr_o;

    int n_vec = 0;
    int n_bad = 0;

    logic [15:0] mw [4][32];
    logic [7:0]  ms [4];
    logic [7:0]  me [4];

    always #10 clk = ~clk;

    dma_chan_regs u_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .eng_vld(eng_vld), .eng_ch(eng_ch),
        .eng_set(eng_set), .eng_code(eng_code), .cmd_start(cmd_start),
        .cmd_abort(cmd_abort), .cmd_halt(cmd_halt), .cmd_cont(cmd_cont),
        .cmd_ch(cmd_ch), .dev_ctl_o(dev_ctl_o), .op_ctl_o(op_ctl_o),
        .seq_ctl_o(seq_ctl_o), .xcnt_o(xcnt_o), .madr_o(madr_o),
        .dadr_o(dadr_o), .bcnt_o(bcnt_o), .badr_o(badr_o)
    );

    function automatic bit is16(input int idx);
        return idx inside {2, 3, 5, 6, 7, 10, 11, 13, 14, 15};
    endfunction

    function automatic bit is8(input int idx);
        return idx inside {18, 19, 20, 22, 24, 28, 31};
    endfunction

    function automatic logic [15:0] exp_rd(input int ch, input int idx);
        if (idx == 0) return {ms[ch], me[ch]};
        if (is16(idx)) return mw[ch][idx];
        if (is8(idx)) return {8'h00, mw[ch][idx][7:0]};
        return 16'h00FF;
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp,
                       input string tag, input string what);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            ms[c] = 8'h00;
            me[c] = 8'h00;
            for (int i = 0; i < 32; i++) mw[c][i] = 16'h0000;
            mw[c][18] = 16'h000F;
            mw[c][19] = 16'h000F;
        end
    endtask

    task automatic model_wr(input int ch, input int idx, input logic [1:0] be,
                            input logic [15:0] d);
        if (idx == 0) begin
            if (be[1]) begin
                ms[ch] = ms[ch] & ~(d[15:8] & 8'hF6);
                if (d[12]) me[ch] = 8'h00;
            end
        end else if (is16(idx)) begin
            if (be[1]) mw[ch][idx][15:8] = d[15:8];
            if (be[0]) mw[ch][idx][7:0]  = d[7:0];
        end else if (is8(idx)) begin
            if (be[0]) mw[ch][idx][7:0] = d[7:0];
        end
    endtask

    task automatic model_eng(input int ch, input logic [7:0] bits, input logic [7:0] code);
        ms[ch] = ms[ch] | bits;
        if (bits[4]) me[ch] = code;
    endtask

    // One cycle: optional bus write and optional engine report, then pulse check
    task automatic cyc(input bit dw, input int ch, input int idx, input logic [1:0] be,
                       input logic [15:0] d, input bit de, input int ech,
                       input logic [7:0] ebits, input logic [7:0] ecode);
        logic [3:0] expc;
        @(negedge clk);
        bus_sel   = dw;
        bus_wr    = dw;
        bus_addr  = {2'(ch), 5'(idx)};
        bus_be    = be;
        bus_wdata = d;
        eng_vld   = de;
        eng_ch    = 2'(ech);
        eng_set   = ebits;
        eng_code  = ecode;
        @(negedge clk);
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
        eng_vld = 1'b0;
        if (dw) model_wr(ch, idx, be, d);
        if (de) model_eng(ech, ebits, ecode);
        expc = (dw && idx == 3 && be[0]) ? {d[7], d[4], d[5], d[6]} : 4'b0000;
        if (expc != 4'b0000) begin
            chk({cmd_start, cmd_abort, cmd_halt, cmd_cont}, expc, "R10", "command pulses");
            chk(cmd_ch, ch, "R10", "command channel");
        end else begin
            chk({cmd_start, cmd_abort, cmd_halt, cmd_cont}, 0, "R11", "no command pulse");
        end
    endtask

    task automatic wr(input int ch, input int idx, input logic [1:0] be, input logic [15:0] d);
        cyc(1'b1, ch, idx, be, d, 1'b0, 0, 8'h00, 8'h00);
    endtask

    task automatic eng(input int ch, input logic [7:0] bits, input logic [7:0] code);
        cyc(1'b0, 0, 0, 2'b00, 16'h0000, 1'b1, ch, bits, code);
    endtask

    task automatic rd(input int ch, input int idx, input string tag);
        @(negedge clk);
        bus_sel  = 1'b1;
        bus_wr   = 1'b0;
        bus_addr = {2'(ch), 5'(idx)};
        @(negedge clk);
        bus_sel = 1'b0;
        chk(bus_rdata, exp_rd(ch, idx), tag, $sformatf("read ch%0d idx%0d", ch, idx));
    endtask

    task automatic chk_exports(input string tag);
        for (int c = 0; c < 4; c++) begin
            chk(dev_ctl_o[c*8 +: 8], mw[c][2][15:8], tag, "dev_ctl export");
            chk(op_ctl_o[c*8 +: 8], mw[c][2][7:0], tag, "op_ctl export");
            chk(seq_ctl_o[c*8 +: 8], mw[c][3][15:8], tag, "seq_ctl export");
            chk(xcnt_o[c*16 +: 16], mw[c][5], tag, "xcnt export");
            chk(madr_o[c*32 +: 32], {mw[c][6], mw[c][7]}, tag, "madr export");
            chk(dadr_o[c*32 +: 32], {mw[c][10], mw[c][11]}, tag, "dadr export");
            chk(bcnt_o[c*16 +: 16], mw[c][13], tag, "bcnt export");
            chk(badr_o[c*32 +: 32], {mw[c][14], mw[c][15]}, tag, "badr export");
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [15:0] held;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the ports
        chk(bus_rdata, 16'h0000, "R1", "rdata after reset");
        chk({cmd_start, cmd_abort, cmd_halt, cmd_cont}, 0, "R1", "pulses after reset");
        chk_exports("R1");
        // R1 and R3: every index of every channel after reset
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 32; i++) rd(c, i, (is16(i) || is8(i) || i == 0) ? "R1" : "R3");

        // R2, R3, R6: distinct pattern into every index of every channel
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 32; i++)
                wr(c, i, 2'b11, 16'(c * 16'h1111) ^ 16'(i * 16'h00A3) ^ 16'h5C0E);
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 32; i++) rd(c, i, "R2");
        chk_exports("R12");

        // R5: single-lane writes
        wr(1, 5, 2'b01, 16'hAAAA);  rd(1, 5, "R5");
        wr(1, 5, 2'b10, 16'h7755);  rd(1, 5, "R5");
        wr(1, 18, 2'b10, 16'h1234); rd(1, 18, "R5");
        wr(1, 2, 2'b01, 16'hBEEF);  rd(1, 2, "R5");
        wr(1, 3, 2'b10, 16'hC3F0);  rd(1, 3, "R5");
        // R6: one address half leaves the other unchanged
        wr(2, 7, 2'b11, 16'h0F0F);  rd(2, 6, "R6"); rd(2, 7, "R6");
        wr(2, 14, 2'b11, 16'hD00D); rd(2, 15, "R6"); rd(2, 14, "R6");
        chk_exports("R12");

        // R9: engine sets every status bit and loads the code
        eng(2, 8'hFF, 8'h5A);       rd(2, 0, "R9");
        // R7 and R8: full clear keeps bits 0 and 3, zeroes the code
        wr(2, 0, 2'b10, 16'hFF00);  rd(2, 0, "R7");
        chk({ms[2], me[2]}, 16'h0900, "R7", "model sanity");
        eng(2, 8'h10, 8'h33);       rd(2, 0, "R9");
        wr(2, 0, 2'b11, 16'h2000);  rd(2, 0, "R8");
        wr(2, 0, 2'b01, 16'hFFFF);  rd(2, 0, "R5");
        // R9: engine set wins over a simultaneous bus clear
        cyc(1'b1, 2, 0, 2'b10, 16'h1000, 1'b1, 2, 8'h10, 8'h44);
        rd(2, 0, "R9");
        eng(3, 8'h30, 8'h77);       rd(3, 0, "R9"); rd(2, 0, "R2");
        wr(3, 0, 2'b10, 16'h0900);  rd(3, 0, "R7");

        // R10: every combination of command bits on every channel
        for (int c = 0; c < 4; c++) begin
            for (int v = 0; v < 16; v++) wr(c, 3, 2'b11, {8'h5A, 4'(v), 4'h9});
            rd(c, 3, "R10");
            wr(c, 3, 2'b01, 16'h00F0);
        end
        // R11: high-lane only and neighbouring index give no pulse
        wr(0, 3, 2'b10, 16'hFFFF);
        wr(0, 2, 2'b11, 16'h00F0);
        wr(0, 1, 2'b11, 16'h00F0);  rd(0, 1, "R3");

        // R4: rdata holds through idle cycles and writes; reads have no effect
        rd(0, 18, "R4");
        held = bus_rdata;
        repeat (3) @(negedge clk);
        chk(bus_rdata, held, "R4", "rdata idle hold");
        wr(0, 18, 2'b11, 16'h0042);
        chk(bus_rdata, held, "R4", "rdata hold over write");
        rd(2, 0, "R4"); rd(2, 0, "R4");
        rd(0, 18, "R4");

        finish_run();
    end

endmodule